// File: doc/BRIEF.md
# Low-Latency Symbol-Mode Line Interface

This block moves 100 Mb/s line traffic between a serial bit stream from the physical-medium layer and a repeater. It does no scrambling, no block coding and no framing. One bit crosses in each direction on every cycle of the bit clock. On receive, five consecutive serial bits are packed into one raw symbol, which is handed to the repeater with a 25 MHz receive symbol clock. On transmit, the repeater offers raw 5-bit symbols against a 25 MHz transmit symbol clock, and the block shifts them onto the serial line. Symbol boundaries come from a free-running divide-by-five counter. No alignment search is made.

Carrier sense is computed from the serial bits one at a time, so it can rise before the symbol that holds the start of carrier is delivered. A mode selector decides whether symbol operation is active. In hardware mode the speed decision comes from a speed pin. In software mode it comes from a control-register bit, and the speed pin turns into an output that reports that bit.

Stream rules: transmit uses valid/ready. `tx_ready` is high for one bit-clock cycle in every five, and only while the block is enabled. A symbol moves on the rising clock edge at which `tx_valid` and `tx_ready` are both high. The source must hold `tx_valid` and `tx_data` stable until that edge. If no symbol is offered in a slot, the block sends an all-ones idle symbol. Receive has no ready signal, because the line cannot be stalled: `rx_valid` pulses once per symbol, and the sink must take the symbol in that cycle.

Top module: `sym_if_top`

## Requirements
- R1: When `hw_sw_sel`=0 (hardware mode), symbol operation is enabled exactly when `if_sel`=1 and `speed_pin_in`=1. `speed_pin_oe` is 0 in this mode.
- R2: When `hw_sw_sel`=1 (software mode), symbol operation is enabled exactly when `if_sel`=1 and `ctrl_speed`=1, whatever `speed_pin_in` is. In this mode `speed_pin_oe`=1 and `speed_pin_out` equals `ctrl_speed`.
- R3: `rx_sym_clk` and `tx_sym_clk` have a period of 5 bit-clock cycles: high for 2 cycles, low for 3. After reset release they stay low for the first 4 cycles and first go high after the 5th rising edge.
- R4: Bits sampled on rising edges 5k+1 to 5k+5 after reset release form one symbol, with the first of them as the MSB (bit 4). The symbol appears on `rx_data` together with a one-cycle `rx_valid` pulse, right after the 5th of those edges, which is also the edge where `rx_sym_clk` rises.
- R5: While symbol operation is disabled, `rx_data` is 0 and `rx_valid` is 0 from the next edge on, whatever `rx_bit` does.
- R6: `carrier` rises on the edge after the sampled bit that completes two 0 bits lying at least 2 positions apart within the latest 10 sampled bits. Two zeros 9 positions apart qualify. Zeros 10 positions apart do not, and neither do two adjacent zeros alone.
- R7: Once high, `carrier` falls on the edge that samples the 10th consecutive 1 bit. It stays high through the 9th.
- R8: `carrier` falls on the next edge when `sig_det` is 0, and it stays 0 while `sig_det` is 0 or symbol operation is disabled.
- R9: A symbol accepted at an edge is sent on `tx_bit` over the next 5 cycles, MSB first.
- R10: A transmit slot with no valid symbol sends five 1 bits. While disabled, `tx_ready`=0 and `tx_bit`=1 constantly, and `tx_data` has no effect.
- R11: During reset, `rx_data`=0, `rx_valid`=0, `carrier`=0, `tx_bit`=1, `tx_ready`=0 and both symbol clocks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_sw_sel | input | 1 | 0 = hardware mode, 1 = software mode |
| if_sel | input | 1 | 1 selects the symbol interface |
| speed_pin_in | input | 1 | Speed pin read as an input (hardware mode) |
| ctrl_speed | input | 1 | Control-register speed bit (software mode) |
| speed_pin_out | output | 1 | Value driven onto the speed pin in software mode |
| speed_pin_oe | output | 1 | Output enable for the speed pin |
| rx_bit | input | 1 | Serial receive bit |
| sig_det | input | 1 | Signal detect from the medium layer |
| rx_sym_clk | output | 1 | 25 MHz receive symbol clock |
| rx_data | output | 5 | Received raw symbol |
| rx_valid | output | 1 | One-cycle pulse marking a new symbol |
| carrier | output | 1 | Bit-serial carrier sense |
| tx_sym_clk | output | 1 | 25 MHz transmit symbol clock |
| tx_data | input | 5 | Transmit raw symbol |
| tx_valid | input | 1 | Transmit symbol offered |
| tx_ready | output | 1 | Transmit slot open this cycle |
| tx_bit | output | 1 | Serial transmit bit |

## Verification
Receive packing is tried with alternating, all-zero, all-one and single-set-bit symbols sent back to back. A swapped bit order, a lost bit or a shifted boundary therefore shows up as a changed value rather than a coincidence. The carrier detector is fed adjacent zeros, zeros spaced exactly 9 and exactly 10 apart, runs of 9 and 10 ones, and a drop of signal detect; these separate a correct window width from an off-by-one window and a missing idle rule. Transmit mixes distinct symbols with an empty slot to show idle fill. The mode pins are walked through both modes to show that only the selected speed source matters.

// File: rtl/sym_pkg.sv
package sym_pkg;
  localparam int SYM_W    = 5;
  localparam int CRS_WIN  = 10;
  localparam int IDLE_RUN = 10;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/sym_mode_sel.sv
module sym_mode_sel (
  input  logic hw_sw_sel,
  input  logic if_sel,
  input  logic speed_pin_in,
  input  logic ctrl_speed,
  output logic sym_en,
  output logic speed_pin_out,
  output logic speed_pin_oe
);
  logic speed_100;

  always_comb begin
    speed_100     = hw_sw_sel ? ctrl_speed : speed_pin_in;
    sym_en        = if_sel & speed_100;
    speed_pin_oe  = hw_sw_sel;
    speed_pin_out = hw_sw_sel & ctrl_speed;
  end
endmodule

// File: rtl/sym_phase_gen.sv
module sym_phase_gen #(
  parameter int SYM_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic ph_last,
  output logic sym_clk
);
  localparam int PH_W = $clog2(SYM_W);
  localparam logic [PH_W-1:0] PH_MAX = PH_W'(SYM_W - 1);

  logic [PH_W-1:0] ph_q;
  logic            sym_clk_q;

  assign ph_last = (ph_q == PH_MAX);
  assign sym_clk = sym_clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q      <= '0;
      sym_clk_q <= 1'b0;
    end else begin
      ph_q      <= ph_last ? '0 : ph_q + 1'b1;
      sym_clk_q <= ph_last | (sym_clk_q & (ph_q == '0));
    end
  end

  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_MAX);
  a_r3_clk_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ph_last |=> sym_clk);
endmodule

// File: rtl/sym_rx_deser.sv
module sym_rx_deser #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ph_last,
  input  logic             rx_bit,
  output logic [SYM_W-1:0] rx_data,
  output logic             rx_valid
);
  logic [SYM_W-2:0] sr_q;
  logic [SYM_W-1:0] data_q;
  logic             valid_q;

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sr_q    <= {sr_q[SYM_W-3:0], rx_bit};
      valid_q <= ph_last & en;
      if (!en)
        data_q <= '0;
      else if (ph_last)
        data_q <= {sr_q, rx_bit};
    end
  end

  a_r4_valid_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_last && en) |=> rx_valid);
  a_r4_lsb_is_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_last && en) |=> rx_data[0] == $past(rx_bit));
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (rx_data == '0 && !rx_valid));
endmodule

// File: rtl/sym_crs_det.sv
module sym_crs_det #(
  parameter int CRS_WIN  = 10,
  parameter int IDLE_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sig_det,
  input  logic rx_bit,
  output logic carrier
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(IDLE_RUN);

  logic [CRS_WIN-2:0] hist_q;
  logic [CRS_WIN-1:0] win;
  logic [RUN_W-1:0]   run_q, run_d;
  logic               pair_hit;
  logic               crs_q;

  assign win     = {hist_q, rx_bit};
  assign carrier = crs_q;

  always_comb begin
    pair_hit = 1'b0;
    for (int i = 0; i < CRS_WIN - 2; i++) begin
      for (int j = i + 2; j < CRS_WIN; j++) begin
        if (!win[i] && !win[j])
          pair_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (!rx_bit)
      run_d = '0;
    else if (run_q == RUN_MAX)
      run_d = run_q;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '1;
      run_q  <= RUN_MAX;
      crs_q  <= 1'b0;
    end else begin
      hist_q <= win[CRS_WIN-2:0];
      run_q  <= run_d;
      if (!en || !sig_det)
        crs_q <= 1'b0;
      else if (pair_hit)
        crs_q <= 1'b1;
      else if (run_d == RUN_MAX)
        crs_q <= 1'b0;
    end
  end

  a_r8_drop_on_no_signal: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_det || !en) |=> !carrier);
  a_r6_rise_needs_zero_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carrier) |-> $past(sig_det && en));
endmodule

// File: rtl/sym_tx_ser.sv
module sym_tx_ser #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ph_last,
  input  logic             tx_valid,
  input  logic [SYM_W-1:0] tx_data,
  output logic             tx_ready,
  output logic             tx_bit
);
  logic [SYM_W-1:0] sh_q;

  assign tx_ready = en & ph_last;
  assign tx_bit   = sh_q[SYM_W-1] | ~en;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sh_q <= '1;
    else if (ph_last)
      sh_q <= (en && tx_valid) ? tx_data : '1;
    else
      sh_q <= {sh_q[SYM_W-2:0], 1'b1};
  end

  a_r9_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_valid) |=> (!en || tx_bit == $past(tx_data[SYM_W-1])));
  a_r10_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> tx_bit);
  a_r10_no_slot_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!tx_ready && tx_bit));
endmodule

// File: rtl/sym_if_top.sv
module sym_if_top
  import sym_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_sw_sel,
  input  logic       if_sel,
  input  logic       speed_pin_in,
  input  logic       ctrl_speed,
  output logic       speed_pin_out,
  output logic       speed_pin_oe,
  input  logic       rx_bit,
  input  logic       sig_det,
  output logic       rx_sym_clk,
  output logic [4:0] rx_data,
  output logic       rx_valid,
  output logic       carrier,
  output logic       tx_sym_clk,
  input  logic [4:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_bit
);
  logic sym_en;
  logic ph_last;
  logic sym_clk;

  sym_mode_sel u_mode (
    .hw_sw_sel    (hw_sw_sel),
    .if_sel       (if_sel),
    .speed_pin_in (speed_pin_in),
    .ctrl_speed   (ctrl_speed),
    .sym_en       (sym_en),
    .speed_pin_out(speed_pin_out),
    .speed_pin_oe (speed_pin_oe)
  );

  sym_phase_gen #(.SYM_W(SYM_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph_last(ph_last),
    .sym_clk(sym_clk)
  );

  assign rx_sym_clk = sym_clk;
  assign tx_sym_clk = sym_clk;

  sym_rx_deser #(.SYM_W(SYM_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sym_en),
    .ph_last (ph_last),
    .rx_bit  (rx_bit),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  sym_crs_det #(.CRS_WIN(CRS_WIN), .IDLE_RUN(IDLE_RUN)) u_crs (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (sym_en),
    .sig_det(sig_det),
    .rx_bit (rx_bit),
    .carrier(carrier)
  );

  sym_tx_ser #(.SYM_W(SYM_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (sym_en),
    .ph_last (ph_last),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_ready(tx_ready),
    .tx_bit  (tx_bit)
  );

  a_r4_valid_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sym_en) && $rose(rx_sym_clk)) |-> rx_valid);
  a_r1_hw_pin_is_input: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_sw_sel |-> !speed_pin_oe);
  a_r2_sw_ignores_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_sw_sel && !ctrl_speed) |-> !tx_ready);
endmodule

// File: tb/sym_if_top_tb_top.sv
module sym_if_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hw_sw_sel, if_sel, speed_pin_in, ctrl_speed;
  logic       speed_pin_out, speed_pin_oe;
  logic       rx_bit, sig_det;
  logic       rx_sym_clk, rx_valid, carrier, tx_sym_clk;
  logic [4:0] rx_data;
  logic [4:0] tx_data;
  logic       tx_valid, tx_ready, tx_bit;

  int total = 0;
  int bad   = 0;

  logic [4:0] rx_q[$];
  logic       tx_q[$];

  always #2 clk = ~clk;

  sym_if_top dut_i (
    .clk(clk), .rst_n(rst_n), .hw_sw_sel(hw_sw_sel), .if_sel(if_sel),
    .speed_pin_in(speed_pin_in), .ctrl_speed(ctrl_speed),
    .speed_pin_out(speed_pin_out), .speed_pin_oe(speed_pin_oe),
    .rx_bit(rx_bit), .sig_det(sig_det), .rx_sym_clk(rx_sym_clk),
    .rx_data(rx_data), .rx_valid(rx_valid), .carrier(carrier),
    .tx_sym_clk(tx_sym_clk), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit(tx_bit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares outputs just after each edge
  always begin
    @(posedge clk);
    #1;
    if (rx_valid && rx_q.size() > 0) begin
      logic [4:0] e;
      e = rx_q.pop_front();
      check("R4 rx symbol", 32'(rx_data), 32'(e));
    end
    if (tx_q.size() > 0) begin
      logic eb;
      eb = tx_q.pop_front();
      check("R9/R10 tx bit", 32'(tx_bit), 32'(eb));
    end
  end

  task automatic drive_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
  endtask

  task automatic align_slot();
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic send_rx(input logic [4:0] s);
    for (int i = 4; i >= 0; i--) drive_bit(s[i]);
    rx_q.push_back(s);
  endtask

  task automatic send_tx(input logic [4:0] s);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = s;
    align_slot();
    for (int i = 4; i >= 0; i--) tx_q.push_back(s[i]);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_idle();
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = 5'b00000;
    align_slot();
    for (int i = 0; i < 5; i++) tx_q.push_back(1'b1);
    @(negedge clk);
  endtask

  task automatic run_all();
    int hi_cnt;
    int first_hi;
    logic saw_ready;
    rst_n = 1'b0; hw_sw_sel = 1'b0; if_sel = 1'b1; speed_pin_in = 1'b1;
    ctrl_speed = 1'b0; rx_bit = 1'b1; sig_det = 1'b1; tx_valid = 1'b0; tx_data = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rx_data", 32'(rx_data), 0);
    check("R11 rx_valid", 32'(rx_valid), 0);
    check("R11 carrier", 32'(carrier), 0);
    check("R11 tx_bit", 32'(tx_bit), 1);
    check("R11 tx_ready", 32'(tx_ready), 0);
    check("R11 rx_sym_clk", 32'(rx_sym_clk), 0);
    check("R11 tx_sym_clk", 32'(tx_sym_clk), 0);
    rst_n = 1'b1;

    // R3 symbol clock timing
    first_hi = 0;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (rx_sym_clk && first_hi == 0) first_hi = n;
    end
    check("R3 first clock rise", 32'(first_hi), 5);
    hi_cnt = 0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      if (rx_sym_clk) hi_cnt++;
      check("R3 tx and rx clocks equal", 32'(tx_sym_clk), 32'(rx_sym_clk));
    end
    check("R3 high cycles per 10", 32'(hi_cnt), 4);
    check("R1 pin is input in hw mode", 32'(speed_pin_oe), 0);

    // R4 receive packing
    align_slot();
    send_rx(5'b10101); send_rx(5'b01010); send_rx(5'b11111);
    send_rx(5'b00000); send_rx(5'b10000); send_rx(5'b00001);
    send_rx(5'b11001);
    repeat (14) drive_bit(1'b1);
    check("R7 carrier clear after idle", 32'(carrier), 0);

    // R6 adjacent zeros only
    drive_bit(1'b0); drive_bit(1'b0);
    repeat (3) drive_bit(1'b1);
    check("R6 adjacent zeros no carrier", 32'(carrier), 0);
    repeat (12) drive_bit(1'b1);
    // R6 zeros 10 apart: outside window
    drive_bit(1'b0); repeat (9) drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1);
    check("R6 zeros 10 apart no carrier", 32'(carrier), 0);
    repeat (12) drive_bit(1'b1);
    // R6 zeros 9 apart: inside window
    drive_bit(1'b0); repeat (8) drive_bit(1'b1); drive_bit(1'b0);
    check("R6 before second zero sampled", 32'(carrier), 0);
    drive_bit(1'b1);
    check("R6 zeros 9 apart carrier", 32'(carrier), 1);
    // R7 deassert on tenth one
    repeat (9) drive_bit(1'b1);
    check("R7 still high after 9 ones", 32'(carrier), 1);
    drive_bit(1'b1);
    check("R7 low after 10 ones", 32'(carrier), 0);

    // R6 quick pair, then R8 signal detect drop
    drive_bit(1'b0); drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1);
    check("R6 pair 0-1-0 carrier", 32'(carrier), 1);
    @(negedge clk); sig_det = 1'b0; rx_bit = 1'b0;
    drive_bit(1'b0);
    check("R8 carrier drops with signal detect", 32'(carrier), 0);
    drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b0);
    check("R8 carrier held low", 32'(carrier), 0);
    sig_det = 1'b1;
    repeat (14) drive_bit(1'b1);

    // R9 / R10 transmit
    send_tx(5'b10011); send_tx(5'b01100); send_tx(5'b00000);
    send_idle();
    send_tx(5'b11110); send_tx(5'b10000);
    repeat (8) @(negedge clk);

    // R5 / R10 disabled behaviour
    if_sel = 1'b0;
    @(negedge clk);
    tx_valid = 1'b1; tx_data = 5'b00000;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      rx_bit = n[0];
      check("R5 rx_data zero when off", 32'(rx_data), 0);
      check("R5 rx_valid zero when off", 32'(rx_valid), 0);
      check("R10 tx_ready low when off", 32'(tx_ready), 0);
      check("R10 tx_bit one when off", 32'(tx_bit), 1);
      check("R8 carrier low when off", 32'(carrier), 0);
    end
    tx_valid = 1'b0;
    rx_bit = 1'b1;

    // R1 hardware mode
    if_sel = 1'b1; speed_pin_in = 1'b0;
    saw_ready = 1'b0;
    repeat (6) begin @(negedge clk); if (tx_ready) saw_ready = 1'b1; end
    check("R1 hw speed low disables", 32'(saw_ready), 0);
    speed_pin_in = 1'b1;
    saw_ready = 1'b0;
    repeat (6) begin @(negedge clk); if (tx_ready) saw_ready = 1'b1; end
    check("R1 hw speed high enables", 32'(saw_ready), 1);

    // R2 software mode
    hw_sw_sel = 1'b1; ctrl_speed = 1'b1; speed_pin_in = 1'b0;
    saw_ready = 1'b0;
    repeat (6) begin @(negedge clk); if (tx_ready) saw_ready = 1'b1; end
    check("R2 sw bit enables", 32'(saw_ready), 1);
    check("R2 pin oe", 32'(speed_pin_oe), 1);
    check("R2 pin out mirrors bit", 32'(speed_pin_out), 1);
    ctrl_speed = 1'b0; speed_pin_in = 1'b1;
    saw_ready = 1'b0;
    repeat (6) begin @(negedge clk); if (tx_ready) saw_ready = 1'b1; end
    check("R2 sw bit low disables", 32'(saw_ready), 0);
    check("R2 pin out low", 32'(speed_pin_out), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule